// File: doc/BRIEF.md
# Edge-Serviced Watchdog Monitor

This block monitors a service line driven by a processor. The processor is expected to toggle the line regularly. Either polarity of transition counts as service. If no transition arrives within a configurable number of clock cycles, the block pulls an active-low watchdog flag. The flag then stays low until the processor toggles the line again.

The timer holds at zero while the system reset is active and resumes counting once that reset lifts. A failing supply also pulls the flag low, in the same cycle and whatever the timer state. The flag recovers as soon as the supply is good again, with no recovery delay.

The block never resets the processor by itself. Integrators that want a reset on timeout route the flag into the manual-reset path of the reset generator.

Top module: `wdog_monitor`

## Requirements
- R1: While the logic reset `rst_n` is low and on the cycle after it is released, `wdog_n` is high, provided `pwr_good` is high.
- R2: With `svc_in` held at a constant level, either high or low, `wdog_n` falls after exactly `TIMEOUT_CYC` rising clock edges counted from the last timer clear, and not one edge earlier.
- R3: A rising or a falling transition of `svc_in` clears the timer. A change applied between clock edges is recognised after two synchronising edges and clears the timer on the third rising edge after the change.
- R4: While `sys_rst_act` is high, the timer is held at zero and no timeout occurs, however long the reset lasts. Counting restarts from zero on the first edge after release.
- R5: Once a timeout has occurred, `wdog_n` stays low, through system reset and further elapsed time, until a `svc_in` transition is recognised.
- R6: After a timeout, a `svc_in` change brings `wdog_n` high on the third rising clock edge after the change, and not on the second. The timer restarts from zero on that edge.
- R7: When a recognised transition and timer expiry fall on the same clock edge, the transition wins. The timer clears and `wdog_n` stays high.
- R8: When `pwr_good` is low, `wdog_n` is low in the same cycle, even if the timer has not expired.
- R9: When `pwr_good` returns high and no timeout is latched, `wdog_n` returns high in the same cycle. A latched timeout keeps it low.
- R10: The internal count never exceeds `TIMEOUT_CYC-1`. After expiry it holds rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low logic reset |
| svc_in | input | 1 | Asynchronous service line from the processor |
| sys_rst_act | input | 1 | High while the system reset is asserted |
| pwr_good | input | 1 | High while the supply is within tolerance |
| wdog_n | output | 1 | Active-low watchdog flag |

## Verification
The bench builds the block with `TIMEOUT_CYC` set to 40 cycles instead of the 160-million-cycle default. With this value, a full expiry, the recovery after it and a second expiry all fit in a few hundred cycles. The short window also lets the bench place a service change so that it is recognised on exactly the expiry edge, which exercises R7. The synchroniser depth stays at its default of two, so the three-edge recognition latency in R3 and R6 is checked exactly.

// File: rtl/wdog_pkg.sv
// Package: shared constants, helpers and types for the watchdog monitor.
// Assumes the clock frequency is given in Hz and fits in 32 bits.
package wdog_pkg;

    // Default clock frequency of the monitor.
    localparam int unsigned DEF_CLK_HZ = 100_000_000;

    // Converts a period in tenths of a second into clock cycles.
    function automatic int unsigned tenths_to_cycles(int unsigned clk_hz, int unsigned tenths);
        return (clk_hz / 10) * tenths;
    endfunction

    // Synchronised view of the service line.
    typedef struct packed {
        logic level;   // synchronised level
        logic toggle;  // one-cycle marker: level changed
    } svc_evt_t;

endpackage

// File: rtl/svc_sync_edge.sv
// Module: svc_sync_edge
// Brings the asynchronous service line into the clock domain through a
// chain of SYNC_STAGES flops and marks every change of the synchronised
// level, whichever its polarity.
// Assumes SYNC_STAGES >= 2. The chain is not reset, so the line must hold
// steady for SYNC_STAGES+1 cycles of logic reset to avoid a spurious mark.
module svc_sync_edge
    import wdog_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     svc_in,
    output svc_evt_t evt_o
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    // Build the synchroniser chain one stage at a time.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw line.
            always_ff @(posedge clk) begin
                chain[0] <= svc_in;
            end
        end else begin : g_next
            // Later stages shift the sample along.
            always_ff @(posedge clk) begin
                chain[g] <= chain[g-1];
            end
        end
    end

    // Hold the previous synchronised level for change detection.
    always_ff @(posedge clk) begin
        last_q <= chain[SYNC_STAGES-1];
    end

    // Report the level and any change of it.
    always_comb begin
        evt_o.level  = chain[SYNC_STAGES-1];
        evt_o.toggle = chain[SYNC_STAGES-1] ^ last_q;
    end

endmodule

// File: rtl/wd_timer.sv
// Module: wd_timer
// Counts cycles since the last clear and latches a timeout when the count
// reaches TIMEOUT_CYC-1 with no clear pending. Priority: clear (service
// change) over hold (system reset) over counting.
// Assumes TIMEOUT_CYC >= 2.
module wd_timer #(
    parameter int unsigned TIMEOUT_CYC = 160_000_000,
    localparam int unsigned CNT_W      = $clog2(TIMEOUT_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             hold_i,
    output logic             expired_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;

    // Advance, clear or hold the count and latch expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (clear_i) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (hold_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            exp_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = exp_q;
    assign count_o   = cnt_q;

endmodule

// File: rtl/wd_flag.sv
// Module: wd_flag
// Forms the active-low watchdog flag from the latched timeout and the
// supply state. Combinational, so supply loss and recovery act at once.
module wd_flag (
    input  logic pwr_good,
    input  logic expired_i,
    output logic wdog_n
);

    // Flag is high only with a good supply and no latched timeout.
    always_comb begin
        wdog_n = pwr_good && !expired_i;
    end

endmodule

// File: rtl/wdog_monitor.sv
// Module: wdog_monitor (top)
// Watches a processor service line and drives an active-low flag on a
// missing transition or on supply loss. Does not reset anything itself.
// Assumes a single clock domain. svc_in may be asynchronous; the other
// inputs are synchronous.
module wdog_monitor
    import wdog_pkg::*;
#(
    parameter int unsigned CLK_HZ      = DEF_CLK_HZ,
    parameter int unsigned TIMEOUT_CYC = tenths_to_cycles(CLK_HZ, 16),
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic svc_in,
    input  logic sys_rst_act,
    input  logic pwr_good,
    output logic wdog_n
);

    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC);

    svc_evt_t         svc_evt;
    logic             tmo;
    logic [CNT_W-1:0] tmr_cnt;

    svc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .svc_in (svc_in),
        .evt_o  (svc_evt)
    );

    wd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (svc_evt.toggle),
        .hold_i    (sys_rst_act),
        .expired_o (tmo),
        .count_o   (tmr_cnt)
    );

    wd_flag u_flag (
        .pwr_good  (pwr_good),
        .expired_i (tmo),
        .wdog_n    (wdog_n)
    );

endmodule

// File: rtl/wdog_monitor_chk.sv
// Module: wdog_monitor_chk
// Temporal checks on the watchdog monitor, bound into the top module.
module wdog_monitor_chk #(
    parameter int unsigned TIMEOUT_CYC = 40,
    parameter int unsigned CNT_W       = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_rst_act,
    input logic             pwr_good,
    input logic             svc_toggle,
    input logic             tmo,
    input logic [CNT_W-1:0] cnt,
    input logic             wdog_n
);

    a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_act |=> (cnt == '0));

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(TIMEOUT_CYC - 1));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !svc_toggle) |=> tmo);

    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        svc_toggle |=> (!tmo && cnt == '0));

    a_r2_expiry_point: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo) |-> ($past(cnt) == CNT_W'(TIMEOUT_CYC - 1)));

    a_r8_pwr_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> !wdog_n);

    a_r9_pwr_back: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !tmo) |-> wdog_n);

endmodule

bind wdog_monitor wdog_monitor_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst_act (sys_rst_act),
    .pwr_good    (pwr_good),
    .svc_toggle  (svc_evt.toggle),
    .tmo         (tmo),
    .cnt         (tmr_cnt),
    .wdog_n      (wdog_n)
);

// File: tb/tb_wdog_monitor.sv
// Directed bench for wdog_monitor. Inputs change and outputs are sampled
// on falling clock edges.
module tb_wdog_monitor;

    localparam int unsigned T = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic svc_in = 1'b0;
    logic sys_rst_act = 1'b0;
    logic pwr_good = 1'b1;
    logic wdog_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    wdog_monitor #(.TIMEOUT_CYC(T)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .svc_in      (svc_in),
        .sys_rst_act (sys_rst_act),
        .pwr_good    (pwr_good),
        .wdog_n      (wdog_n)
    );

    always #5 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp);
        total++;
        if (wdog_n !== exp) begin
            bad++;
            $display("FAIL %s: wdog_n=%0b expected %0b at %0t", req, wdog_n, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(4);
        rst_n = 1'b1;
    endtask

    // R1 and R2: reset state, then expiry with the line held low.
    task automatic t_reset_and_const_low();
        svc_in = 1'b0;
        do_reset();
        chk("R1 flag high on reset release", 1'b1);
        step(T - 1);
        chk("R2 no expiry one edge early (low)", 1'b1);
        step(1);
        chk("R2 expiry at TIMEOUT (low)", 1'b0);
        step(50);
        chk("R5/R10 still low long after expiry", 1'b0);
    endtask

    // R6: recovery from a timeout, then R2 with the line held high.
    task automatic t_recover();
        svc_in = 1'b1;
        step(2);
        chk("R6 not yet high after two edges", 1'b0);
        step(1);
        chk("R6 high on third edge", 1'b1);
        step(T - 1);
        chk("R2 no expiry one edge early (high)", 1'b1);
        step(1);
        chk("R2 expiry at TIMEOUT (high)", 1'b0);
    endtask

    // R3: regular service of both polarities keeps the flag high.
    task automatic t_keep_alive();
        svc_in = 1'b0;
        do_reset();
        for (int i = 0; i < 6; i++) begin
            step(T / 2);
            svc_in = ~svc_in;
            chk("R3 serviced, flag high", 1'b1);
        end
        svc_in = 1'b0;
        step(T / 2);
        svc_in = 1'b1;
        step(T / 2);
        svc_in = 1'b0;
        step(3);
        step(T - 1);
        chk("R3 falling edge restarted timer", 1'b1);
        step(1);
        chk("R3 expiry after falling edge", 1'b0);
    endtask

    // R4 and R5: system reset holds the timer; timeout is sticky.
    task automatic t_sysrst();
        svc_in = 1'b1;
        do_reset();
        sys_rst_act = 1'b1;
        step(3 * T);
        chk("R4 no timeout during system reset", 1'b1);
        sys_rst_act = 1'b0;
        step(T - 1);
        chk("R4 count restarts at release", 1'b1);
        step(1);
        chk("R4 expiry TIMEOUT after release", 1'b0);
        sys_rst_act = 1'b1;
        step(10);
        chk("R5 stays low during system reset", 1'b0);
        sys_rst_act = 1'b0;
        step(5);
        chk("R5 stays low after system reset", 1'b0);
        svc_in = 1'b0;
        step(3);
        chk("R5 released by transition", 1'b1);
    endtask

    // R7: a transition on the expiry edge wins.
    task automatic t_tie();
        svc_in = 1'b1;
        do_reset();
        step(T - 3);
        svc_in = 1'b0;
        step(3);
        chk("R7 transition wins on expiry edge", 1'b1);
        step(T - 1);
        chk("R7 timer restarted from zero", 1'b1);
        step(1);
        chk("R7 later expiry", 1'b0);
    endtask

    // R8 and R9: supply loss and recovery act at once.
    task automatic t_power();
        svc_in = 1'b0;
        do_reset();
        step(5);
        pwr_good = 1'b0;
        #1;
        chk("R8 flag low on supply loss", 1'b0);
        step(3);
        chk("R8 flag held low", 1'b0);
        pwr_good = 1'b1;
        #1;
        chk("R9 flag high on recovery", 1'b1);
        step(T);
        chk("R9 timeout latched", 1'b0);
        pwr_good = 1'b0;
        step(2);
        pwr_good = 1'b1;
        #1;
        chk("R9 latched timeout keeps flag low", 1'b0);
    endtask

    initial begin
        step(1);
        t_reset_and_const_low();
        t_recover();
        t_keep_alive();
        t_sysrst();
        t_tie();
        t_power();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule